// File: doc/BRIEF.md
# Multi-Port Interrupt Cause Aggregator

This block collects single-cycle event pulses from the ports of up to two host-controller groups and latches them into one 32-bit main cause word. Each port has an error event and a completion event. Each group also has one coalesced-completion event. A secondary cause register latches host-bus error events, and its masked OR appears as one summary bit of the main cause word. The main cause word is ANDed with a main mask, and the result drives a single registered interrupt line.

Software reaches the four registers through a small register bus that uses word-index addresses: 0 main cause, 1 main mask, 2 bus-error cause, 3 bus-error mask. Writing 1 to a main cause bit clears it. Writing 0 to a bus-error cause bit clears it, so writing back the complement of a value read earlier clears exactly the bits that were set in that value. Read data is registered.

Top module: `irq_cause_agg`

## Requirements
- R1: A pulse on port_err_pulse[4*g+p] sets main cause bit 2*p+9*g. The bit stays set until software clears it.
- R2: A pulse on port_done_pulse[4*g+p] sets main cause bit 2*p+9*g+1, which is one position above the error bit of the same port.
- R3: A pulse on coal_done_pulse[g] sets main cause bit 9*g+8. With two groups, these are bits 8 and 17.
- R4: Main cause bit 18 reads as the live OR of (bus-error cause AND bus-error mask). It changes as soon as either register changes. Writing the main cause register has no effect on bit 18 or on the bus-error cause.
- R5: Writing the main cause register (address 0) clears each bit written as 1. Bits written as 0 are kept.
- R6: Writing the bus-error cause register (address 2) clears each bit written as 0. Bits written as 1 are kept. Writing the complement of an earlier read clears only the bits that were set in that read, and events latched after the read are kept.
- R7: If a set pulse and a clear write hit the same cause bit in the same cycle, the bit ends up set.
- R8: After reset, all four registers read 0 and irq_o is 0.
- R9: irq_o is 1 exactly one cycle after any bit of (main cause AND main mask) is 1. Unmasked cause bits never raise it.
- R10: Bits 19 to 31 of the main cause and main mask read as 0 and ignore writes. Bits 0 to 18 of the main mask are writable.
- R11: The main mask uses the main cause bit layout, so a single done enable can be set or cleared by a read-modify-write of the mask without disturbing the other bits.
- R12: A read on reg_rd_en returns data on reg_rdata after the next clock edge. reg_rdata holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_err_pulse | input | 8 | Per-port error event pulses, index 4*group+port |
| port_done_pulse | input | 8 | Per-port completion event pulses, index 4*group+port |
| coal_done_pulse | input | 2 | Per-group coalesced completion pulses |
| bus_err_pulse | input | 8 | Host-bus error event pulses into the bus-error cause |
| reg_addr | input | 2 | Register word index (0 main cause, 1 main mask, 2 bus cause, 3 bus mask) |
| reg_wr_en | input | 1 | Write strobe |
| reg_rd_en | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A pulse that is present before clock edge N is visible in the cause registers from edge N. Because the summary bit is combinational, it follows at edge N as well. irq_o reflects that cause at edge N+1, and a read issued in the cycle after the pulse returns it after the edge that samples the read. The bench drives every stimulus on the falling edge and samples on the falling edge after the edge that is due. For the interrupt line, it first checks that irq_o is still low one falling edge after the cause was latched, then checks that it is high on the next falling edge. Clears follow the same count: irq_o falls one edge after the clearing write takes effect.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;
  typedef enum logic [1:0] {
    SEL_MAIN_CAUSE = 2'd0,
    SEL_MAIN_MASK  = 2'd1,
    SEL_BUS_CAUSE  = 2'd2,
    SEL_BUS_MASK   = 2'd3
  } reg_sel_e;

  // bit index of the error event of port p in group g
  function automatic int err_bit(input int g, input int p, input int stride);
    return 2 * p + stride * g;
  endfunction
endpackage

// File: rtl/irq_agg_pack.sv
`timescale 1ns/1ps
module irq_agg_pack #(
  parameter int NUM_GRP = 2,
  parameter int PORTS   = 4,
  parameter int STRIDE  = 9,
  parameter int DATA_W  = 32
) (
  input  logic [NUM_GRP*PORTS-1:0] err_i,
  input  logic [NUM_GRP*PORTS-1:0] done_i,
  input  logic [NUM_GRP-1:0]       coal_i,
  output logic [DATA_W-1:0]        set_o,
  output logic [DATA_W-1:0]        keep_o
);
  import irq_agg_pkg::*;

  localparam int COAL_OFS = STRIDE - 1;

  always_comb begin
    set_o  = '0;
    keep_o = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      for (int p = 0; p < PORTS; p++) begin
        set_o[err_bit(g, p, STRIDE)]      = err_i[g*PORTS+p];
        set_o[err_bit(g, p, STRIDE) + 1]  = done_i[g*PORTS+p];
        keep_o[err_bit(g, p, STRIDE)]     = 1'b1;
        keep_o[err_bit(g, p, STRIDE) + 1] = 1'b1;
      end
      set_o[STRIDE*g + COAL_OFS]  = coal_i[g];
      keep_o[STRIDE*g + COAL_OFS] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_sticky_reg.sv
`timescale 1ns/1ps
module irq_sticky_reg #(
  parameter int W           = 32,
  parameter bit CLR_ON_ZERO = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] keep_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] clr;

  generate
    if (CLR_ON_ZERO) begin : g_clr_zero
      assign clr = wr_i ? ~wdata_i : '0;
    end else begin : g_clr_one
      assign clr = wr_i ? wdata_i : '0;
    end
  endgenerate

  // set has priority over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= ((q_o & ~clr) | set_i) & keep_i;
  end
endmodule

// File: rtl/irq_cause_agg.sv
`timescale 1ns/1ps
module irq_cause_agg #(
  parameter int NUM_GRP = 2,
  parameter int PORTS   = 4,
  parameter int STRIDE  = 9,
  parameter int SUM_BIT = 18,
  parameter int DATA_W  = 32,
  parameter int SEC_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_GRP*PORTS-1:0] port_err_pulse,
  input  logic [NUM_GRP*PORTS-1:0] port_done_pulse,
  input  logic [NUM_GRP-1:0]       coal_done_pulse,
  input  logic [SEC_W-1:0]         bus_err_pulse,
  input  logic [1:0]               reg_addr,
  input  logic                     reg_wr_en,
  input  logic                     reg_rd_en,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  output logic                     irq_o
);
  import irq_agg_pkg::*;

  localparam logic [DATA_W-1:0] SUM_ONEHOT = DATA_W'(1) << SUM_BIT;

  reg_sel_e          sel;
  logic [DATA_W-1:0] set_word, keep_word, mask_writable;
  logic [DATA_W-1:0] main_cause_q, main_mask_q, cause_view;
  logic [SEC_W-1:0]  sec_cause_q, sec_mask_q;
  logic              sum_live;
  logic              wr_main_cause, wr_sec_cause;

  assign sel           = reg_sel_e'(reg_addr);
  assign wr_main_cause = reg_wr_en && (sel == SEL_MAIN_CAUSE);
  assign wr_sec_cause  = reg_wr_en && (sel == SEL_BUS_CAUSE);

  irq_agg_pack #(
    .NUM_GRP(NUM_GRP), .PORTS(PORTS), .STRIDE(STRIDE), .DATA_W(DATA_W)
  ) u_pack (
    .err_i(port_err_pulse), .done_i(port_done_pulse), .coal_i(coal_done_pulse),
    .set_o(set_word), .keep_o(keep_word)
  );

  irq_sticky_reg #(.W(DATA_W), .CLR_ON_ZERO(1'b0)) u_main_cause (
    .clk(clk), .rst(rst), .set_i(set_word), .keep_i(keep_word),
    .wr_i(wr_main_cause), .wdata_i(reg_wdata), .q_o(main_cause_q)
  );

  irq_sticky_reg #(.W(SEC_W), .CLR_ON_ZERO(1'b1)) u_sec_cause (
    .clk(clk), .rst(rst), .set_i(bus_err_pulse), .keep_i({SEC_W{1'b1}}),
    .wr_i(wr_sec_cause), .wdata_i(reg_wdata[SEC_W-1:0]), .q_o(sec_cause_q)
  );

  assign sum_live      = |(sec_cause_q & sec_mask_q);
  assign cause_view    = main_cause_q | (sum_live ? SUM_ONEHOT : '0);
  assign mask_writable = keep_word | SUM_ONEHOT;

  always_ff @(posedge clk) begin
    if (rst) begin
      main_mask_q <= '0;
      sec_mask_q  <= '0;
    end else if (reg_wr_en) begin
      if (sel == SEL_MAIN_MASK) main_mask_q <= reg_wdata & mask_writable;
      if (sel == SEL_BUS_MASK)  sec_mask_q  <= reg_wdata[SEC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(cause_view & main_mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd_en) begin
      unique case (sel)
        SEL_MAIN_CAUSE: reg_rdata <= cause_view;
        SEL_MAIN_MASK:  reg_rdata <= main_mask_q;
        SEL_BUS_CAUSE:  reg_rdata <= DATA_W'(sec_cause_q);
        SEL_BUS_MASK:   reg_rdata <= DATA_W'(sec_mask_q);
      endcase
    end
  end
endmodule

// File: rtl/irq_agg_checker.sv
`timescale 1ns/1ps
module irq_agg_checker #(
  parameter int DATA_W  = 32,
  parameter int SEC_W   = 8,
  parameter int SUM_BIT = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_o,
  input logic [1:0]        reg_addr,
  input logic              reg_wr_en,
  input logic              reg_rd_en,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [DATA_W-1:0] main_cause_q,
  input logic [DATA_W-1:0] main_mask_q,
  input logic [DATA_W-1:0] set_word,
  input logic [SEC_W-1:0]  sec_cause_q
);
  // R8: registers cleared by reset
  a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (main_mask_q == '0 && main_cause_q == '0 && sec_cause_q == '0 && !irq_o));

  // R9: the interrupt needs an enabled mask bit one cycle earlier
  a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && irq_o) |-> ($past(main_mask_q) != '0));

  // R7: a set pulse always lands, whatever write happens alongside
  a_r7_set_sticks: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((main_cause_q & $past(set_word)) == $past(set_word)));

  // R5: main cause bits drop only after a write to the main cause
  a_r5_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(reg_wr_en && reg_addr == 2'd0))
      |-> ((main_cause_q & $past(main_cause_q)) == $past(main_cause_q)));

  // R6: bus-error cause bits drop only after a write to that register
  a_r6_bus_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(reg_wr_en && reg_addr == 2'd2))
      |-> ((sec_cause_q & $past(sec_cause_q)) == $past(sec_cause_q)));

  // R10: upper bits of main cause and mask read as zero
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reg_rd_en && reg_addr[1] == 1'b0))
      |-> (reg_rdata[DATA_W-1:SUM_BIT+1] == '0));
endmodule

bind irq_cause_agg irq_agg_checker #(
  .DATA_W(DATA_W), .SEC_W(SEC_W), .SUM_BIT(SUM_BIT)
) u_chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .reg_addr(reg_addr),
  .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata),
  .main_cause_q(main_cause_q), .main_mask_q(main_mask_q),
  .set_word(set_word), .sec_cause_q(sec_cause_q)
);

// File: tb/tb_irq_cause_agg.sv
`timescale 1ns/1ps
module tb_irq_cause_agg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  port_err_pulse = '0, port_done_pulse = '0, bus_err_pulse = '0;
  logic [1:0]  coal_done_pulse = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  irq_cause_agg dut (
    .clk(clk), .rst(rst), .port_err_pulse(port_err_pulse),
    .port_done_pulse(port_done_pulse), .coal_done_pulse(coal_done_pulse),
    .bus_err_pulse(bus_err_pulse), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd_en = 1'b1;
    @(negedge clk); reg_rd_en = 1'b0; d = reg_rdata;
  endtask

  function automatic int pos(input int g, input int p);
    return 2 * p + 9 * g;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    check("R8 irq", {31'd0, irq_o}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d); check("R8 reg", d, 0);
    end

    // R1 R2 R5 sweep over every port and event kind
    for (int g = 0; g < 2; g++)
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 2; k++) begin
          logic [31:0] b;
          b = 32'd1 << (pos(g, p) + k);
          @(negedge clk);
          if (k == 0) port_err_pulse[g*4+p] = 1'b1; else port_done_pulse[g*4+p] = 1'b1;
          @(negedge clk); port_err_pulse = '0; port_done_pulse = '0;
          repeat (2) @(negedge clk);
          rd(0, d); check(k == 0 ? "R1 err bit sticky" : "R2 done bit sticky", d, b);
          wr(0, ~b);
          rd(0, d); check("R5 zeros keep bit", d, b);
          wr(0, b);
          rd(0, d); check("R5 one clears bit", d, 0);
        end

    // R3 coalesced-done bits
    for (int g = 0; g < 2; g++) begin
      @(negedge clk); coal_done_pulse[g] = 1'b1;
      @(negedge clk); coal_done_pulse = '0;
      rd(0, d); check("R3 coal bit", d, 32'd1 << (9 * g + 8));
      wr(0, 32'hFFFF_FFFF);
    end

    // R9 interrupt timing and gating
    wr(1, 32'd1 << pos(1, 2));
    check("R9 idle irq", {31'd0, irq_o}, 0);
    @(negedge clk); port_err_pulse[6] = 1'b1;
    @(negedge clk); port_err_pulse = '0;
    check("R9 irq not yet", {31'd0, irq_o}, 0);
    @(negedge clk);
    check("R9 irq one cycle later", {31'd0, irq_o}, 1);
    @(negedge clk); port_err_pulse[0] = 1'b1;
    @(negedge clk); port_err_pulse = '0;
    wr(0, 32'd1 << pos(1, 2));
    @(negedge clk);
    check("R9 unmasked bit no irq", {31'd0, irq_o}, 0);
    rd(0, d); check("R9 unmasked still latched", d, 32'd1);
    wr(0, 32'd1);

    // R7 set wins over clear
    @(negedge clk); port_done_pulse[0] = 1'b1;
    reg_addr = 0; reg_wdata = 32'd2; reg_wr_en = 1'b1;
    @(negedge clk); port_done_pulse = '0; reg_wr_en = 1'b0;
    rd(0, d); check("R7 set wins", d, 32'd2);
    wr(0, 32'd2);

    // R4 R6 bus-error cause and summary bit
    wr(3, 32'hFF);
    @(negedge clk); bus_err_pulse = 8'h05;
    @(negedge clk); bus_err_pulse = '0;
    rd(2, d); check("R6 bus cause latched", d, 32'h05);
    m = d;
    rd(0, d); check("R4 summary bit", d, 32'd1 << 18);
    @(negedge clk); bus_err_pulse = 8'h02;
    @(negedge clk); bus_err_pulse = '0;
    wr(2, ~m);
    rd(2, d); check("R6 complement clears only read bits", d, 32'h02);
    wr(0, 32'd1 << 18);
    rd(2, d); check("R4 main write leaves bus cause", d, 32'h02);
    rd(0, d); check("R4 summary still set", d, 32'd1 << 18);
    wr(3, 32'h0);
    rd(0, d); check("R4 summary follows mask", d, 0);
    wr(3, 32'h02);
    wr(1, 32'd1 << 18);
    @(negedge clk);
    check("R4 summary drives irq", {31'd0, irq_o}, 1);
    wr(2, 32'hFFFF_FFFD);
    @(negedge clk);
    check("R4 irq drops after bus clear", {31'd0, irq_o}, 0);
    rd(2, d); check("R6 bus cause empty", d, 0);

    // R10 reserved bits
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); check("R10 mask writable bits", d, 32'h0007_FFFF);
    wr(1, 32'h0);
    @(negedge clk);
    port_err_pulse = 8'hFF; port_done_pulse = 8'hFF; coal_done_pulse = 2'b11;
    @(negedge clk); port_err_pulse = '0; port_done_pulse = '0; coal_done_pulse = '0;
    rd(0, d); check("R10 all events, upper bits zero", d, 32'h0003_FFFF);
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); check("R10 all cleared", d, 0);

    // R11 read-modify-write of done enables
    rd(1, m); wr(1, m | (32'd1 << (pos(1, 3) + 1)));
    rd(1, d); check("R11 enable g1p3 done", d, 32'h0001_0000);
    rd(1, m); wr(1, m | (32'd1 << (pos(0, 0) + 1)));
    rd(1, d); check("R11 enable g0p0 done", d, 32'h0001_0002);
    rd(1, m); wr(1, m & ~(32'd1 << (pos(1, 3) + 1)));
    rd(1, d); check("R11 disable g1p3 done", d, 32'h0000_0002);

    // R12 read data holds between reads
    repeat (3) @(negedge clk);
    check("R12 rdata held", reg_rdata, 32'h0000_0002);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule